// File: doc/BRIEF.md
# Two-Tier Interrupt Priority Controller

This block collects level-sensitive interrupt requests from sixteen on-chip peripherals and from two external request pins, and turns them into one interrupt request for a processor. The first tier works on the peripherals. Every peripheral has a channel number and a service vector, both set by software. On every clock the first tier picks the highest-priority active peripheral. It then drives exactly one of seven channel lines, together with the vector of that peripheral. This stage is registered.

The second tier stands on the processor side. It filters the channel line and the two external pins through a per-source enable register and a two-bit global mask level. It then latches one winning source and presents that source's vector. The request is held until the processor returns a one-cycle acknowledge, or until the held source withdraws its request.

Software configures the block through a simple write port. Because the global mask acts after the channels, the most restrictive global level silences every peripheral at once.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Among the active peripheral requests whose channel code is 0 to 6, the one with the highest channel code wins; on equal channel codes the lowest input index wins. A code of 7 never wins. The channel outputs reflect the requests sampled at the previous rising edge.
- R2: At most one channel line is high, and it is the line numbered by the winner's channel code. `ch_vec` carries the winner's vector, or 0 when no line is high. With no peripheral request, no line is high one clock later.
- R3: A write with `cfg_we` high takes effect at the next rising edge. Address n (0 to 15) sets peripheral n: data bits [2:0] give the channel code and bits [7:3] give the vector. Address 16 sets the enables: bit 0 is pin A, bit 1 is pin B, and bit 2+n is channel n. Address 17 sets the global mask level from bits [1:0].
- R4: After reset every enable is 0, the global level is 3, and every peripheral has channel 0 and vector 0. No interrupt is raised until software enables one.
- R5: A channel whose enable bit is 0 never causes `irq_req`.
- R6: Each external pin is enabled by its own bit. A pin can cause an interrupt only while the global level is 0. Pin A presents vector 0x1E and pin B presents vector 0x1F.
- R7: Global level 0 admits all sources. Level 1 admits only channels 4 to 6. Level 2 admits only channel 6. Level 3 admits nothing.
- R8: When several admitted candidates are pending together, the channel line wins over pin A, and pin A wins over pin B.
- R9: `irq_req` rises one clock after an admitted candidate is visible to the processor-side tier. While it is high, the vector stays fixed even if higher-priority requests arrive.
- R10: An `irq_ack` pulse while `irq_req` is high drops `irq_req` at the next edge. Arbitration resumes one clock later, so a source that is still pending is raised again.
- R11: If the held source withdraws its request, `irq_req` falls at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_req | input | 16 | Level-sensitive peripheral requests |
| ext_req_a | input | 1 | External request pin A, level-sensitive |
| ext_req_b | input | 1 | External request pin B, level-sensitive |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration write address |
| cfg_wdata | input | 9 | Configuration write data |
| irq_ack | input | 1 | One-cycle acknowledge from the processor |
| ch_req | output | 7 | Channel request lines from the peripheral tier |
| ch_vec | output | 5 | Vector of the peripheral on the active channel |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 5 | Vector of the held source |

## Verification
The hardest situation to reach from the ports is a held request that must not move while better requests appear. A stronger source cannot displace it; only an acknowledge or a withdrawal releases it.

The stimulus first reaches a held state on a low-priority source, either a channel-0 peripheral or pin B. While the request is held, it raises a channel-6 peripheral or pin A. The bench then confirms that the vector is unchanged. Next it acknowledges and checks for the one-cycle gap followed by the stronger winner.

A separate sequence drops a held peripheral just after re-arbitration. This shows that a stale channel line does not re-latch a withdrawn request.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    // Which kind of source the processor-side tier is holding
    typedef enum logic [1:0] {
        HOLD_NONE  = 2'd0,
        HOLD_CH    = 2'd1,
        HOLD_EXT_A = 2'd2,
        HOLD_EXT_B = 2'd3
    } hold_kind_e;

    localparam logic [1:0] GM_ALL   = 2'b00;
    localparam logic [1:0] GM_HIGH  = 2'b01;
    localparam logic [1:0] GM_TOP   = 2'b10;
    localparam logic [1:0] GM_NONE  = 2'b11;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int NUM_SRC = 16,
    parameter int NUM_CH  = 7,
    parameter int CH_W    = 3,
    parameter int VEC_W   = 5,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 9
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [ADDR_W-1:0]                 cfg_addr,
    input  logic [DATA_W-1:0]                 cfg_wdata,
    output logic [NUM_SRC-1:0][CH_W-1:0]      src_ch,
    output logic [NUM_SRC-1:0][VEC_W-1:0]     src_vec,
    output logic                              ext_a_en,
    output logic                              ext_b_en,
    output logic [NUM_CH-1:0]                 ch_en,
    output logic [1:0]                        gmask
);
    import irq_prio_pkg::*;

    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [ADDR_W-1:0] SRC_LIM   = ADDR_W'(NUM_SRC);
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_SRC);
    localparam logic [ADDR_W-1:0] GM_ADDR   = ADDR_W'(NUM_SRC + 1);

    typedef struct packed {
        logic [NUM_SRC-1:0][CH_W-1:0]  ch;
        logic [NUM_SRC-1:0][VEC_W-1:0] vec;
        logic                          a_en;
        logic                          b_en;
        logic [NUM_CH-1:0]             c_en;
        logic [1:0]                    gm;
    } cfg_t;

    localparam cfg_t CFG_RST = '{ch: '0, vec: '0, a_en: 1'b0, b_en: 1'b0,
                                 c_en: '0, gm: GM_NONE};

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            if (cfg_addr < SRC_LIM) begin
                cfg_d.ch[cfg_addr[SRC_W-1:0]]  = cfg_wdata[CH_W-1:0];
                cfg_d.vec[cfg_addr[SRC_W-1:0]] = cfg_wdata[CH_W +: VEC_W];
            end else if (cfg_addr == MASK_ADDR) begin
                cfg_d.a_en = cfg_wdata[0];
                cfg_d.b_en = cfg_wdata[1];
                cfg_d.c_en = cfg_wdata[2 +: NUM_CH];
            end else if (cfg_addr == GM_ADDR) begin
                cfg_d.gm = cfg_wdata[1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign src_ch   = cfg_q.ch;
    assign src_vec  = cfg_q.vec;
    assign ext_a_en = cfg_q.a_en;
    assign ext_b_en = cfg_q.b_en;
    assign ch_en    = cfg_q.c_en;
    assign gmask    = cfg_q.gm;

    // R3: a global-mask write lands at the next edge
    a_r3_gm_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == GM_ADDR) |=> (gmask == $past(cfg_wdata[1:0])));

endmodule

// File: rtl/irq_periph_arb.sv
module irq_periph_arb #(
    parameter int NUM_SRC = 16,
    parameter int NUM_CH  = 7,
    parameter int CH_W    = 3,
    parameter int VEC_W   = 5,
    parameter int SRC_W   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            periph_req,
    input  logic [NUM_SRC-1:0][CH_W-1:0]  src_ch,
    input  logic [NUM_SRC-1:0][VEC_W-1:0] src_vec,
    output logic [NUM_CH-1:0]             ch_req,
    output logic [VEC_W-1:0]              ch_vec,
    output logic [SRC_W-1:0]              ch_src
);
    localparam logic [CH_W-1:0] CH_LIM = CH_W'(NUM_CH);

    typedef struct packed {
        logic [NUM_CH-1:0] req;
        logic [VEC_W-1:0]  vec;
        logic [SRC_W-1:0]  src;
    } arb_t;

    arb_t arb_d, arb_q;

    always_comb begin
        logic            found;
        logic [CH_W-1:0] best_ch;
        logic [VEC_W-1:0] best_vec;
        logic [SRC_W-1:0] best_src;
        found    = 1'b0;
        best_ch  = '0;
        best_vec = '0;
        best_src = '0;
        // Strict compare keeps the lowest index on equal channel codes
        for (int i = 0; i < NUM_SRC; i++) begin
            if (periph_req[i] && (src_ch[i] < CH_LIM) &&
                (!found || (src_ch[i] > best_ch))) begin
                found    = 1'b1;
                best_ch  = src_ch[i];
                best_vec = src_vec[i];
                best_src = SRC_W'(i);
            end
        end
        arb_d     = '0;
        if (found) begin
            arb_d.req[best_ch] = 1'b1;
            arb_d.vec          = best_vec;
            arb_d.src          = best_src;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

    assign ch_req = arb_q.req;
    assign ch_vec = arb_q.vec;
    assign ch_src = arb_q.src;

    // R2: never more than one channel line
    a_r2_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_req));

    // R2: no request in, no line out one clock later
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_req == '0) |=> (ch_req == '0 && ch_vec == '0));

endmodule

// File: rtl/irq_core_gate.sv
module irq_core_gate #(
    parameter int              NUM_SRC   = 16,
    parameter int              NUM_CH    = 7,
    parameter int              CH_W      = 3,
    parameter int              VEC_W     = 5,
    parameter int              SRC_W     = 4,
    parameter int              GM1_MIN   = 4,
    parameter int              GM2_MIN   = 6,
    parameter logic [VEC_W-1:0] EXT_A_VEC = 5'h1E,
    parameter logic [VEC_W-1:0] EXT_B_VEC = 5'h1F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    ch_req,
    input  logic [VEC_W-1:0]     ch_vec,
    input  logic [SRC_W-1:0]     ch_src,
    input  logic [NUM_SRC-1:0]   periph_req,
    input  logic                 ext_a,
    input  logic                 ext_b,
    input  logic                 ext_a_en,
    input  logic                 ext_b_en,
    input  logic [NUM_CH-1:0]    ch_en,
    input  logic [1:0]           gmask,
    input  logic                 irq_ack,
    output logic                 irq_req,
    output logic [VEC_W-1:0]     irq_vec
);
    import irq_prio_pkg::*;

    localparam logic [CH_W-1:0] LVL1 = CH_W'(GM1_MIN);
    localparam logic [CH_W-1:0] LVL2 = CH_W'(GM2_MIN);

    typedef struct packed {
        logic             busy;
        hold_kind_e       kind;
        logic [SRC_W-1:0] src;
        logic [VEC_W-1:0] vec;
    } hold_t;

    hold_t hold_d, hold_q;

    logic [CH_W-1:0] ch_lvl;
    logic            lvl_ok;
    logic            ch_cand;
    logic            a_cand;
    logic            b_cand;
    logic            held_live;

    always_comb begin
        ch_lvl = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_req[c]) ch_lvl = CH_W'(c);
        end
        case (gmask)
            GM_ALL:  lvl_ok = 1'b1;
            GM_HIGH: lvl_ok = (ch_lvl >= LVL1);
            GM_TOP:  lvl_ok = (ch_lvl >= LVL2);
            default: lvl_ok = 1'b0;
        endcase
        // The raw request guards against a line that lags a withdrawal
        ch_cand = |(ch_req & ch_en) && lvl_ok && periph_req[ch_src];
        a_cand  = ext_a && ext_a_en && (gmask == GM_ALL);
        b_cand  = ext_b && ext_b_en && (gmask == GM_ALL);
        case (hold_q.kind)
            HOLD_CH:    held_live = periph_req[hold_q.src];
            HOLD_EXT_A: held_live = ext_a;
            HOLD_EXT_B: held_live = ext_b;
            default:    held_live = 1'b0;
        endcase
    end

    always_comb begin
        hold_d = hold_q;
        if (hold_q.busy) begin
            if (irq_ack || !held_live) begin
                hold_d.busy = 1'b0;
                hold_d.kind = HOLD_NONE;
            end
        end else if (ch_cand) begin
            hold_d = '{busy: 1'b1, kind: HOLD_CH, src: ch_src, vec: ch_vec};
        end else if (a_cand) begin
            hold_d = '{busy: 1'b1, kind: HOLD_EXT_A, src: '0, vec: EXT_A_VEC};
        end else if (b_cand) begin
            hold_d = '{busy: 1'b1, kind: HOLD_EXT_B, src: '0, vec: EXT_B_VEC};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '{busy: 1'b0, kind: HOLD_NONE, src: '0, vec: '0};
        else        hold_q <= hold_d;
    end

    assign irq_req = hold_q.busy;
    assign irq_vec = hold_q.vec;

    // R9: a held, live, unacknowledged request keeps its vector
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q.busy && !irq_ack && held_live) |=> (irq_req && $stable(irq_vec)));

    // R10: acknowledge releases the request at the next edge
    a_r10_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req);

    // R7: the closed global level never starts a request
    a_r7_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (gmask == GM_NONE && !irq_req) |=> !irq_req);

    // R6: without a channel line, pins alone need level 0
    a_r6_pins_need_open: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && ch_req == '0 && gmask != GM_ALL) |=> !irq_req);

    // R11: a held pin A that drops releases the request
    a_r11_pin_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && hold_q.kind == HOLD_EXT_A && !ext_a) |=> !irq_req);

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int NUM_SRC = 16,
    parameter int NUM_CH  = 7,
    parameter int VEC_W   = 5,
    parameter int CH_W    = $clog2(NUM_CH + 1),
    parameter int ADDR_W  = $clog2(NUM_SRC + 2),
    parameter int DATA_W  = ((CH_W + VEC_W) > (NUM_CH + 2)) ? (CH_W + VEC_W) : (NUM_CH + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] periph_req,
    input  logic               ext_req_a,
    input  logic               ext_req_b,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic               irq_ack,
    output logic [NUM_CH-1:0]  ch_req,
    output logic [VEC_W-1:0]   ch_vec,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec
);
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0][CH_W-1:0]  src_ch;
    logic [NUM_SRC-1:0][VEC_W-1:0] src_vec;
    logic                          ext_a_en;
    logic                          ext_b_en;
    logic [NUM_CH-1:0]             ch_en;
    logic [1:0]                    gmask;
    logic [SRC_W-1:0]              ch_src;

    irq_cfg_regs #(
        .NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH), .CH_W(CH_W), .VEC_W(VEC_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .src_ch(src_ch), .src_vec(src_vec),
        .ext_a_en(ext_a_en), .ext_b_en(ext_b_en), .ch_en(ch_en), .gmask(gmask)
    );

    irq_periph_arb #(
        .NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH), .CH_W(CH_W), .VEC_W(VEC_W), .SRC_W(SRC_W)
    ) arb_i (
        .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .src_ch(src_ch),
        .src_vec(src_vec), .ch_req(ch_req), .ch_vec(ch_vec), .ch_src(ch_src)
    );

    irq_core_gate #(
        .NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH), .CH_W(CH_W), .VEC_W(VEC_W), .SRC_W(SRC_W)
    ) gate_i (
        .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_vec(ch_vec), .ch_src(ch_src),
        .periph_req(periph_req), .ext_a(ext_req_a), .ext_b(ext_req_b),
        .ext_a_en(ext_a_en), .ext_b_en(ext_b_en), .ch_en(ch_en), .gmask(gmask),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec)
    );

endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;

    localparam logic [4:0] MASK_A = 5'd16;
    localparam logic [4:0] GM_A   = 5'd17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] periph_req = '0;
    logic        ext_req_a = 1'b0;
    logic        ext_req_b = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [8:0]  cfg_wdata = '0;
    logic        irq_ack = 1'b0;
    logic [6:0]  ch_req;
    logic [4:0]  ch_vec;
    logic        irq_req;
    logic [4:0]  irq_vec;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .ext_req_a(ext_req_a),
        .ext_req_b(ext_req_b), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .irq_ack(irq_ack), .ch_req(ch_req), .ch_vec(ch_vec),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    // {requests, expected channel lines, expected vector}
    localparam logic [27:0] TABLE [10] = '{
        {16'h0000, 7'b0000000, 5'd0},
        {16'h0001, 7'b0000100, 5'd2},
        {16'h0006, 7'b0100000, 5'd3},
        {16'h0011, 7'b1000000, 5'd6},
        {16'h8008, 7'b0010000, 5'd17},
        {16'h0840, 7'b0010000, 5'd13},
        {16'h0408, 7'b0000010, 5'd12},
        {16'hFFFF, 7'b1000000, 5'd6},
        {16'h0028, 7'b0001000, 5'd7},
        {16'h0008, 7'b0000001, 5'd5}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [4:0] a, input logic [8:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    function automatic logic [2:0] chan_of(input int i);
        case (i)
            0: return 3'd2;
            1, 2: return 3'd5;
            3: return 3'd0;
            4: return 3'd6;
            5: return 3'd3;
            default: return (i <= 10) ? 3'd1 : 3'd4;
        endcase
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R4: quiet after reset, and nothing enabled
        check("R4 irq after reset", 32'(irq_req), 32'd0);
        check("R4 lines after reset", 32'(ch_req), 32'd0);
        periph_req = 16'hFFFF; ext_req_a = 1'b1; ext_req_b = 1'b1;
        tick(); tick(); tick();
        check("R4 nothing enabled", 32'(irq_req), 32'd0);
        check("R1 default channel 0 index 0", 32'({ch_req, ch_vec}), 32'({7'b0000001, 5'd0}));
        periph_req = '0; ext_req_a = 1'b0; ext_req_b = 1'b0;
        tick();

        // R3: program channel codes and vectors
        for (int i = 0; i < 16; i++) begin
            cfg_write(5'(i), {5'(i + 2), chan_of(i)});
        end

        // R1 R2 table walk, global level still closed (R7)
        for (int k = 0; k < 10; k++) begin
            periph_req = TABLE[k][27:12];
            tick();
            check("R1 channel lines", 32'(ch_req), 32'(TABLE[k][11:5]));
            check("R2 channel vector", 32'(ch_vec), 32'(TABLE[k][4:0]));
            check("R7 level 3 blocks", 32'(irq_req), 32'd0);
        end
        periph_req = '0;
        tick();

        // R6 R9 R10 R11 with pin A
        cfg_write(MASK_A, 9'h001);
        cfg_write(GM_A, 9'd0);
        ext_req_a = 1'b1;
        tick();
        check("R9 pin A raised", 32'({irq_req, irq_vec}), 32'({1'b1, 5'h1E}));
        ack_pulse();
        check("R10 drop after ack", 32'(irq_req), 32'd0);
        tick();
        check("R10 re-raise", 32'({irq_req, irq_vec}), 32'({1'b1, 5'h1E}));
        ext_req_a = 1'b0;
        tick();
        check("R11 pin withdrawn", 32'(irq_req), 32'd0);

        // R6 R8 R9 with pin B
        ext_req_b = 1'b1;
        tick(); tick();
        check("R6 pin B disabled", 32'(irq_req), 32'd0);
        cfg_write(MASK_A, 9'h003);
        tick();
        check("R6 pin B vector", 32'({irq_req, irq_vec}), 32'({1'b1, 5'h1F}));
        ext_req_a = 1'b1;
        tick(); tick();
        check("R9 held against pin A", 32'({irq_req, irq_vec}), 32'({1'b1, 5'h1F}));
        ack_pulse();
        check("R10 gap", 32'(irq_req), 32'd0);
        tick();
        check("R8 pin A over pin B", 32'({irq_req, irq_vec}), 32'({1'b1, 5'h1E}));
        ext_req_a = 1'b0; ext_req_b = 1'b0;
        cfg_write(MASK_A, 9'h000);
        check("R11 both pins gone", 32'(irq_req), 32'd0);
        tick();

        // R5 R8 R11 channel against pin
        periph_req = 16'h0001;
        tick(); tick(); tick();
        check("R5 channel disabled", 32'(irq_req), 32'd0);
        ext_req_a = 1'b1;
        cfg_write(MASK_A, 9'h011);
        tick();
        check("R8 channel over pin A", 32'({irq_req, irq_vec}), 32'({1'b1, 5'd2}));
        ack_pulse();
        check("R10 channel ack", 32'(irq_req), 32'd0);
        tick();
        check("R10 channel re-raise", 32'({irq_req, irq_vec}), 32'({1'b1, 5'd2}));
        periph_req = '0;
        tick();
        check("R11 peripheral withdrawn", 32'(irq_req), 32'd0);
        tick();
        check("R11 no stale relatch, pin A next", 32'({irq_req, irq_vec}), 32'({1'b1, 5'h1E}));
        ext_req_a = 1'b0;
        tick();
        check("R11 pin A gone", 32'(irq_req), 32'd0);

        // R7 global levels 1 and 2
        cfg_write(MASK_A, 9'h1FF);
        cfg_write(GM_A, 9'd1);
        periph_req = 16'h0020;
        tick(); tick(); tick();
        check("R7 level 1 blocks channel 3", 32'(irq_req), 32'd0);
        periph_req = 16'h8000;
        tick(); tick();
        check("R7 level 1 admits channel 4", 32'({irq_req, irq_vec}), 32'({1'b1, 5'd17}));
        periph_req = '0;
        tick();
        check("R11 drop channel 4", 32'(irq_req), 32'd0);
        ext_req_a = 1'b1;
        tick(); tick();
        check("R6 pin needs level 0", 32'(irq_req), 32'd0);
        ext_req_a = 1'b0;
        cfg_write(GM_A, 9'd2);
        periph_req = 16'h8000;
        tick(); tick(); tick();
        check("R7 level 2 blocks channel 4", 32'(irq_req), 32'd0);
        periph_req = 16'h0010;
        tick(); tick();
        check("R7 level 2 admits channel 6", 32'({irq_req, irq_vec}), 32'({1'b1, 5'd6}));
        periph_req = '0;
        tick();

        // R9 R10 held low channel against channel 6
        cfg_write(GM_A, 9'd0);
        periph_req = 16'h0008;
        tick(); tick();
        check("R9 channel 0 raised", 32'({irq_req, irq_vec}), 32'({1'b1, 5'd5}));
        periph_req = 16'h0018;
        tick(); tick();
        check("R9 held against channel 6", 32'({irq_req, irq_vec}), 32'({1'b1, 5'd5}));
        check("R1 line moved to channel 6", 32'(ch_req), 32'(7'b1000000));
        ack_pulse();
        check("R10 gap before winner", 32'(irq_req), 32'd0);
        tick();
        check("R10 channel 6 wins", 32'({irq_req, irq_vec}), 32'({1'b1, 5'd6}));
        periph_req = '0;
        tick();
        check("R11 all quiet", 32'(irq_req), 32'd0);

        finish_run();
    end

endmodule